// File: doc/BRIEF.md
# Clock Output Mode and Gating Controller

This block sits between the configuration registers of a clock generator and its output pads. It takes the mode and frequency-select register, three output-enable registers and an external frequency-select pin. From them it produces the code that steers the frequency synthesizer, a spread-modulation request, and the final state of thirteen clock outputs: the value each output drives and whether its driver is enabled.

The nominal clock sources (CPU rate, PCI rate, reference, 48 MHz and the strap-selected 24/48 MHz clock) come in as digital inputs and are sampled on the block clock `clk_i`. Each output is registered once. A global two-bit mode chooses one of four behaviours: normal, spread, high impedance, or a test bypass in which every output is derived from the reference input divided by 1, 2 or 4. Per-output enable bits hold individual outputs low. An enable change is accepted only while the source of that output is low, so gating never shortens a high pulse.

Top module: `clkout_mode_ctrl`

## Requirements
- R1: With mode `ctl_reg_i[1:0]`=00, `clk_o` is registered one cycle behind its source. CPU outputs follow `cpu_clk_i`, PCI outputs `pci_clk_i`, APIC and REF `ref_clk_i`, USB `usb_clk_i` and AUX `aux_clk_i`. All `clk_oe_o` bits are 1.
- R2: Mode 10 routes sources exactly as mode 00 and sets `spread_en_o`=1. In every other mode `spread_en_o` is 0.
- R3: In mode 01 the CPU and USB outputs carry the reference divided by 2, the PCI and AUX outputs the reference divided by 4, and APIC and REF carry `ref_clk_i` directly. The divide-by-2 signal starts at 0 after reset and toggles on every sampled rising edge of `ref_clk_i`. The divide-by-4 signal starts at 0 and toggles on every second such edge.
- R4: Mode 11 drives all `clk_oe_o` bits to 0 and holds all `clk_o` bits at 0 from the next cycle on. This overrides the enables and the test bypass.
- R5: When `ctl_reg_i[3]`=0, `synth_sel_o` is 3'b111 if `freq_sel_pin_i`=1 and 3'b011 if it is 0. When `ctl_reg_i[3]`=1, `synth_sel_o` equals `ctl_reg_i[6:4]`.
- R6: An enable bit of 1 lets an output run and 0 holds it low while its driver stays on. The bits are mapped as follows. `cpu_en_reg_i[0]`→`clk_o[0]` and `cpu_en_reg_i[2]`→`clk_o[1]`. `pci_en_reg_i[7]`→`clk_o[2]`. `pci_en_reg_i[3:0]`→`clk_o[6:3]`, and `pci_en_reg_i[5]`→`clk_o[7]`, `pci_en_reg_i[6]`→`clk_o[8]`. `per_en_reg_i[5]`→`clk_o[9]`. `clk_o[11]` (USB) and `clk_o[12]` (AUX) have no disable.
- R7: REF (`clk_o[10]`) is enabled only when `per_en_reg_i[1:0]`=11. `ref_cfg_err_o` is 1 exactly when those two bits differ.
- R8: A new enable value is taken only on a clock edge where the output's source is sampled low. An output therefore falls only after its source was low (or after mode 11), and never cuts a high pulse short.
- R9: Reserved bits have no effect on any output. These are `ctl_reg_i[7]`, `ctl_reg_i[2]`, `cpu_en_reg_i[7:3]`, `cpu_en_reg_i[1]`, `pci_en_reg_i[4]`, `per_en_reg_i[7:6]` and `per_en_reg_i[4:2]`.
- R10: During and after reset all `clk_o` bits are 0, every internal enable is cleared and both reference dividers are at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | block clock, samples all sources |
| rst_ni | input | 1 | active-low asynchronous reset |
| ctl_reg_i | input | 8 | mode [1:0], table select [3], frequency code [6:4] |
| cpu_en_reg_i | input | 8 | CPU output enables |
| pci_en_reg_i | input | 8 | PCI output enables |
| per_en_reg_i | input | 8 | APIC and REF enables |
| freq_sel_pin_i | input | 1 | external frequency select |
| ref_clk_i | input | 1 | reference clock source |
| cpu_clk_i | input | 1 | CPU-rate clock source |
| pci_clk_i | input | 1 | PCI-rate clock source |
| usb_clk_i | input | 1 | 48 MHz clock source |
| aux_clk_i | input | 1 | strap-selected 24/48 MHz source |
| clk_o | output | 13 | gated output values: CPU0, CPU1, PCI_F, PCI1..6, APIC, REF, USB, AUX |
| clk_oe_o | output | 13 | per-output driver enable, 0 means high impedance |
| spread_en_o | output | 1 | spread modulation request |
| synth_sel_o | output | 3 | synthesizer frequency code |
| ref_cfg_err_o | output | 1 | REF enable bits disagree |

## Verification
The bench toggles every source at a different rate and changes the enable registers while sources are high. A design that applied enables at once would emit runt pulses that differ from the bench's expected waveform. Test mode runs long enough for the divide-by-4 phase to cycle several times, which catches a divider that counts every edge or is tapped from the wrong stage. Mode 11 is applied with all enables set and during the test bypass, so a design that lets either one win over high impedance shows live outputs. The enable mapping is swept with reserved bits set, and the REF bits are tried in all four combinations. A swapped bit position or a REF gate that uses OR instead of AND therefore fails.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  localparam int REG_W   = 8;
  localparam int SEL_W   = 3;
  localparam int NUM_PCI = 6;
  localparam int NUM_OUT = NUM_PCI + 7;

  localparam int IDX_CPU0 = 0;
  localparam int IDX_CPU1 = 1;
  localparam int IDX_PCIF = 2;
  localparam int IDX_PCI1 = 3;
  localparam int IDX_APIC = IDX_PCI1 + NUM_PCI;
  localparam int IDX_REF  = IDX_APIC + 1;
  localparam int IDX_USB  = IDX_REF + 1;
  localparam int IDX_AUX  = IDX_USB + 1;

  localparam logic [SEL_W-1:0] CODE_PIN_HI = 3'b111;
  localparam logic [SEL_W-1:0] CODE_PIN_LO = 3'b011;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_TEST   = 2'b01,
    MODE_SPREAD = 2'b10,
    MODE_HIZ    = 2'b11
  } mode_e;

  typedef enum logic [2:0] {SRC_CPU, SRC_PCI, SRC_REF, SRC_USB, SRC_AUX} src_cls_e;

  function automatic src_cls_e out_class(int idx);
    if (idx <= IDX_CPU1)      return SRC_CPU;
    else if (idx < IDX_APIC)  return SRC_PCI;
    else if (idx <= IDX_REF)  return SRC_REF;
    else if (idx == IDX_USB)  return SRC_USB;
    else                      return SRC_AUX;
  endfunction
endpackage

// File: rtl/clkout_cfg_decode.sv
module clkout_cfg_decode
  import clkout_pkg::*;
(
  input  logic [REG_W-1:0]   ctl_reg_i,
  input  logic [REG_W-1:0]   cpu_en_reg_i,
  input  logic [REG_W-1:0]   pci_en_reg_i,
  input  logic [REG_W-1:0]   per_en_reg_i,
  input  logic               freq_sel_pin_i,
  output mode_e              mode_o,
  output logic [SEL_W-1:0]   synth_sel_o,
  output logic               spread_en_o,
  output logic [NUM_OUT-1:0] out_en_o,
  output logic               ref_cfg_err_o
);
  localparam int TBL_BIT   = 3;
  localparam int CODE_LSB  = 4;
  localparam int CPU0_BIT  = 0;
  localparam int CPU1_BIT  = 2;
  localparam int PCIF_BIT  = 7;
  localparam int APIC_BIT  = 5;
  localparam int PCI_GAP   = 4;  // bit 4 of the PCI register is unused

  assign mode_o      = mode_e'(ctl_reg_i[1:0]);
  assign spread_en_o = (mode_o == MODE_SPREAD);
  assign synth_sel_o = ctl_reg_i[TBL_BIT] ? ctl_reg_i[CODE_LSB +: SEL_W]
                     : (freq_sel_pin_i ? CODE_PIN_HI : CODE_PIN_LO);

  assign ref_cfg_err_o = per_en_reg_i[1] ^ per_en_reg_i[0];

  always_comb begin
    out_en_o           = '1;
    out_en_o[IDX_CPU0] = cpu_en_reg_i[CPU0_BIT];
    out_en_o[IDX_CPU1] = cpu_en_reg_i[CPU1_BIT];
    out_en_o[IDX_PCIF] = pci_en_reg_i[PCIF_BIT];
    for (int j = 0; j < NUM_PCI; j++)
      out_en_o[IDX_PCI1+j] = pci_en_reg_i[(j < PCI_GAP) ? j : j + 1];
    out_en_o[IDX_APIC] = per_en_reg_i[APIC_BIT];
    out_en_o[IDX_REF]  = per_en_reg_i[1] & per_en_reg_i[0];
  end
endmodule

// File: rtl/clkout_ref_div.sv
module clkout_ref_div (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic div2_o,
  output logic div4_o
);
  logic ref_d, div2_q, div4_q;
  logic ref_rise;

  assign ref_rise = ref_i & ~ref_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_d  <= 1'b0;
      div2_q <= 1'b0;
      div4_q <= 1'b0;
    end else begin
      ref_d <= ref_i;
      if (ref_rise) begin
        div2_q <= ~div2_q;
        if (div2_q) div4_q <= ~div4_q;
      end
    end
  end

  assign div2_o = div2_q;
  assign div4_o = div4_q;

  AST_DIV2_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(div2_q) |-> ($past(ref_i) && !$past(ref_d))); // R3
  AST_DIV4_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(div4_q) |-> $fell(div2_q)); // R3
endmodule

// File: rtl/clkout_gate_cell.sv
module clkout_gate_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic en_i,
  input  logic hiz_i,
  output logic clk_o
);
  logic en_q, out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      out_q <= 1'b0;
    end else begin
      if (!src_i) en_q <= en_i;  // accept gating only in low phase
      out_q <= src_i & en_q & ~hiz_i;
    end
  end

  assign clk_o = out_q;

  AST_EN_LOW_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(en_q) |-> !$past(src_i)); // R8
  AST_NO_RUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_q) |-> (!$past(src_i) || $past(hiz_i))); // R8
  AST_HOLD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !out_q); // R6
endmodule

// File: rtl/clkout_mode_ctrl.sv
module clkout_mode_ctrl
  import clkout_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [REG_W-1:0]   ctl_reg_i,
  input  logic [REG_W-1:0]   cpu_en_reg_i,
  input  logic [REG_W-1:0]   pci_en_reg_i,
  input  logic [REG_W-1:0]   per_en_reg_i,
  input  logic               freq_sel_pin_i,
  input  logic               ref_clk_i,
  input  logic               cpu_clk_i,
  input  logic               pci_clk_i,
  input  logic               usb_clk_i,
  input  logic               aux_clk_i,
  output logic [NUM_OUT-1:0] clk_o,
  output logic [NUM_OUT-1:0] clk_oe_o,
  output logic               spread_en_o,
  output logic [SEL_W-1:0]   synth_sel_o,
  output logic               ref_cfg_err_o
);
  mode_e              mode;
  logic [NUM_OUT-1:0] out_en;
  logic               div2, div4, hiz, test;

  clkout_cfg_decode u_dec (
    .ctl_reg_i      (ctl_reg_i),
    .cpu_en_reg_i   (cpu_en_reg_i),
    .pci_en_reg_i   (pci_en_reg_i),
    .per_en_reg_i   (per_en_reg_i),
    .freq_sel_pin_i (freq_sel_pin_i),
    .mode_o         (mode),
    .synth_sel_o    (synth_sel_o),
    .spread_en_o    (spread_en_o),
    .out_en_o       (out_en),
    .ref_cfg_err_o  (ref_cfg_err_o)
  );

  clkout_ref_div u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ref_i  (ref_clk_i),
    .div2_o (div2),
    .div4_o (div4)
  );

  assign hiz      = (mode == MODE_HIZ);
  assign test     = (mode == MODE_TEST);
  assign clk_oe_o = {NUM_OUT{~hiz}};

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    localparam src_cls_e CLS = out_class(g);
    logic src;

    always_comb begin
      unique case (CLS)
        SRC_CPU: src = test ? div2 : cpu_clk_i;
        SRC_PCI: src = test ? div4 : pci_clk_i;
        SRC_REF: src = ref_clk_i;
        SRC_USB: src = test ? div2 : usb_clk_i;
        default: src = test ? div4 : aux_clk_i;
      endcase
    end

    clkout_gate_cell u_gate (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .src_i  (src),
      .en_i   (out_en[g]),
      .hiz_i  (hiz),
      .clk_o  (clk_o[g])
    );
  end

  AST_HIZ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_reg_i[1:0] == 2'b11) |=> (clk_o == '0)); // R4
  AST_PIN_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_reg_i[3] |-> (synth_sel_o[1:0] == 2'b11 && synth_sel_o[2] == freq_sel_pin_i)); // R5
  AST_SPREAD_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spread_en_o |-> (clk_oe_o == '1)); // R2
  AST_REF_ERR_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_cfg_err_o && !ref_clk_i) |=> ##1 !clk_o[IDX_REF]); // R7
endmodule

// File: tb/clkout_mode_ctrl_test.sv
module clkout_mode_ctrl_test;
  import clkout_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] ctl = '0, cpu_en = '0, pci_en = '0, per_en = '0;
  logic pin = 1'b0, ref_c = 1'b0, cpu_c = 1'b0, pci_c = 1'b0, usb_c = 1'b0, aux_c = 1'b0;
  logic [12:0] clk_o, oe_o;
  logic spread_o, err_o;
  logic [2:0] sel_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int n = 0;
  int k = 0;
  logic ref_prev = 1'b0;
  logic [12:0] en_m = '0, out_m = '0;

  always #10 clk = ~clk;

  clkout_mode_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .ctl_reg_i(ctl), .cpu_en_reg_i(cpu_en),
    .pci_en_reg_i(pci_en), .per_en_reg_i(per_en), .freq_sel_pin_i(pin),
    .ref_clk_i(ref_c), .cpu_clk_i(cpu_c), .pci_clk_i(pci_c), .usb_clk_i(usb_c),
    .aux_clk_i(aux_c), .clk_o(clk_o), .clk_oe_o(oe_o), .spread_en_o(spread_o),
    .synth_sel_o(sel_o), .ref_cfg_err_o(err_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // R6/R7 bit mapping
  function automatic logic [12:0] exp_en();
    logic [12:0] e;
    e[0] = cpu_en[0];  e[1] = cpu_en[2];  e[2] = pci_en[7];
    e[3] = pci_en[0];  e[4] = pci_en[1];  e[5] = pci_en[2];  e[6] = pci_en[3];
    e[7] = pci_en[5];  e[8] = pci_en[6];  e[9] = per_en[5];
    e[10] = per_en[1] & per_en[0];
    e[11] = 1'b1;      e[12] = 1'b1;
    return e;
  endfunction

  // R1/R3 source per output
  function automatic logic [12:0] exp_src();
    logic [12:0] s;
    logic t, d2, d4;
    t  = (ctl[1:0] == 2'b01);
    d2 = (k % 2) != 0;
    d4 = ((k / 2) % 2) != 0;
    for (int i = 0; i < 13; i++) begin
      if (i < 2)        s[i] = t ? d2 : cpu_c;
      else if (i < 9)   s[i] = t ? d4 : pci_c;
      else if (i < 11)  s[i] = ref_c;
      else if (i == 11) s[i] = t ? d2 : usb_c;
      else              s[i] = t ? d4 : aux_c;
    end
    return s;
  endfunction

  task automatic run(int cnt, string tag);
    logic [12:0] src, env;
    logic hz;
    for (int c = 0; c < cnt; c++) begin
      cpu_c = (n % 2) != 0;
      pci_c = ((n / 2) % 2) != 0;
      usb_c = ((n / 3) % 2) != 0;
      aux_c = ((n / 4) % 2) != 0;
      ref_c = ((n / 5) % 2) != 0;
      #1;
      src = exp_src();
      env = exp_en();
      hz  = (ctl[1:0] == 2'b11);
      chk({tag, " oe R4"}, 32'(oe_o), hz ? 32'h0 : 32'h1fff);
      chk({tag, " spread R2"}, 32'(spread_o), 32'(ctl[1:0] == 2'b10));
      @(posedge clk);
      out_m = src & en_m & {13{~hz}};
      for (int i = 0; i < 13; i++) if (!src[i]) en_m[i] = env[i];
      if (ref_c && !ref_prev) k++;
      ref_prev = ref_c;
      n++;
      @(negedge clk);
      chk({tag, " out R8"}, 32'(clk_o), 32'(out_m));
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cpu_en = 8'h05; pci_en = 8'hEF; per_en = 8'h23;
    repeat (3) @(negedge clk);
    cpu_c = 1'b1; pci_c = 1'b1; ref_c = 1'b1; usb_c = 1'b1; aux_c = 1'b1;
    @(negedge clk);
    chk("reset R10", 32'(clk_o), 32'h0);
    cpu_c = 1'b0; pci_c = 1'b0; ref_c = 1'b0; usb_c = 1'b0; aux_c = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    ctl = 8'h00; pin = 1'b1; run(40, "normal R1");
    pin = 1'b0;  run(20, "normal pin R1");
    ctl = 8'h02; run(30, "spread R2");
    ctl = 8'h01; run(80, "test R3");
    ctl = 8'h03; run(20, "hiz R4");
    ctl = 8'h01; run(10, "test back R3");
    ctl = 8'h03; run(10, "hiz over test R4");

    for (int p = 0; p < 16; p++) begin
      cpu_en = p[0] ? 8'h05 : (p[1] ? 8'h01 : 8'h04);
      pci_en = {4'(p), 4'(p)} ^ 8'h5A;
      per_en = {2'b00, p[2], 3'b000, p[1], p[0]};
      ctl    = p[3] ? 8'h02 : 8'h00;
      run(10, "enable map R6 R7");
    end

    ctl = 8'h84; cpu_en = 8'hFA; pci_en = 8'h10; per_en = 8'hDC;
    run(20, "reserved normal R9");
    ctl = 8'h85; run(30, "reserved test R9");
    cpu_en = 8'hFF; pci_en = 8'hFF; per_en = 8'hFF; ctl = 8'h84;
    run(20, "all on R9");

    for (int c = 0; c < 16; c++) begin
      for (int pv = 0; pv < 2; pv++) begin
        ctl = {1'b0, 3'(c), c[3], 3'b000};
        pin = pv[0];
        #1;
        chk("synth code R5", 32'(sel_o), c[3] ? 32'(c % 8) : (pv[0] ? 32'd7 : 32'd3));
      end
    end

    for (int r = 0; r < 4; r++) begin
      per_en = {6'b0, 2'(r)};
      #1;
      chk("ref err R7", 32'(err_o), 32'((r == 1) || (r == 2)));
    end

    for (int m = 0; m < 4; m++) begin
      ctl = {6'b0, 2'(m)};
      #1;
      chk("spread flag R2", 32'(spread_o), 32'(m == 2));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule